// File: doc/BRIEF.md
# Partitioned Radix-4 Booth Mantissa Multiplier

This block multiplies two unsigned 24-bit mantissas with radix-4 Booth recoding and returns a 48-bit product one clock later. A two-bit mode input, sampled with each operation, reconfigures the same partial-product array. It can produce one full-width product, two independent half-width products, or four independent quarter-width products. Every lane reads its operand slices at their natural bit positions and writes its product into the matching slice of the 48-bit result. A floating-point datapath can therefore try a cheap low-precision pass first and fall back to a wider one, with no change of wiring between passes.

The split modes do not use separate multipliers. Each Booth digit selects only the multiplicand slice of its own lane. The multiplier recoding restarts at every active lane edge. Each partial product is clipped to its lane's output field, so sign-extension bits cannot spill into a neighbour. The final summation runs as a chain of segments, and the carry between two segments is cut wherever a lane edge lies. One new operation is accepted on every clock, and the mode may differ from one operation to the next.

Top module: `vp_booth_mul`

## Requirements
- R1: While `rst_n` is low, `out_vld_o` is 0 and `prod_o` is all zeros.
- R2: `out_vld_o` equals the `in_vld_i` value sampled at the previous rising clock edge, so one operation is accepted on every cycle with a latency of one cycle.
- R3: With `mode_i` = 2'b00, `prod_o` becomes the full 48-bit unsigned product `a_i * b_i`.
- R4: With `mode_i` = 2'b01, lane k (k = 0, 1) multiplies `a_i[12k+11:12k]` by `b_i[12k+11:12k]`, and the 24-bit product appears at `prod_o[24k+23:24k]`.
- R5: With `mode_i` = 2'b10, lane k (k = 0..3) multiplies `a_i[6k+5:6k]` by `b_i[6k+5:6k]`, and the 12-bit product appears at `prod_o[12k+11:12k]`.
- R6: `mode_i` = 2'b11 gives the same result as 2'b00.
- R7: In a split mode, the result field of a lane depends only on that lane's operand slices. Operand patterns that produce negative Booth digits in one lane never alter another lane's field.
- R8: The mode is taken per operation, so back-to-back operations with different modes each return the result of their own mode.
- R9: Operands whose lane top bit is 1 are treated as unsigned. All-ones lanes of width n give (2^n - 1)^2 in their field.
- R10: A cycle with `in_vld_i` low leaves `prod_o` at its previous value, whatever the operand and mode inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld_i | input | 1 | Operation present on the inputs this cycle |
| mode_i | input | 2 | 00 one lane, 01 two lanes, 10 four lanes, 11 as 00 |
| a_i | input | 24 | Multiplicand, lanes at natural positions |
| b_i | input | 24 | Multiplier, lanes at natural positions |
| out_vld_o | output | 1 | Result present on `prod_o` |
| prod_o | output | 48 | Product, lane k of width n at bits [2nk+2n-1:2nk] |

## Verification
Every error in this block reaches `prod_o` on the edge that follows the operation, because the only state is the output register. A recoding slip at a lane edge, an unclipped negative partial product or an uncut segment carry is therefore visible in the very next result. Such a fault shows up as a wrong field in the lane that leaked or as a corrupted low bit in the lane above it. The stimulus weights all-ones and alternating-bit slices, since these make the largest and most negative digits, and changes mode on consecutive cycles so that a mode applied to the wrong operation is exposed at once.

// File: rtl/vpm_pkg.sv
package vpm_pkg;

    localparam int NQ = 4;

    typedef enum logic [1:0] {
        VPM_ONE  = 2'b00,
        VPM_TWO  = 2'b01,
        VPM_FOUR = 2'b10,
        VPM_ALT  = 2'b11
    } vpm_mode_e;

    // Lane edge between quarter q-1 and quarter q is active in this mode.
    function automatic logic split_at(input logic [1:0] m, input int q);
        case (m)
            VPM_FOUR: return (q > 0) && (q < NQ);
            VPM_TWO:  return q == NQ / 2;
            default:  return 1'b0;
        endcase
    endfunction

    // First quarter of the lane holding quarter q.
    function automatic int lane_first_q(input logic [1:0] m, input int q);
        case (m)
            VPM_FOUR: return q;
            VPM_TWO:  return (q >= NQ / 2) ? NQ / 2 : 0;
            default:  return 0;
        endcase
    endfunction

    // Number of quarters in one lane.
    function automatic int lane_nq(input logic [1:0] m);
        case (m)
            VPM_FOUR: return 1;
            VPM_TWO:  return NQ / 2;
            default:  return NQ;
        endcase
    endfunction

endpackage

// File: rtl/vpm_booth_digit.sv
module vpm_booth_digit (
    input  logic [2:0] grp_i,
    output logic       neg_o,
    output logic       one_o,
    output logic       two_o
);
    always_comb begin
        neg_o = 1'b0;
        one_o = 1'b0;
        two_o = 1'b0;
        case (grp_i)
            3'b001, 3'b010: one_o = 1'b1;
            3'b011:         two_o = 1'b1;
            3'b100: begin   two_o = 1'b1; neg_o = 1'b1; end
            3'b101, 3'b110: begin one_o = 1'b1; neg_o = 1'b1; end
            default: ;
        endcase
    end
endmodule

// File: rtl/vpm_pp_row.sv
module vpm_pp_row #(
    parameter int OPW   = 24,
    parameter int SHIFT = 0,
    parameter int QIDX  = 0
) (
    input  logic [1:0]       mode_i,
    input  logic [OPW-1:0]   a_i,
    input  logic             neg_i,
    input  logic             one_i,
    input  logic             two_i,
    output logic [2*OPW-1:0] pp_o
);
    import vpm_pkg::*;

    localparam int PW   = 2 * OPW;
    localparam int QW   = OPW / NQ;
    localparam int SEGW = 2 * QW;

    logic [OPW-1:0] amask;
    logic [PW-1:0]  fmask;
    logic [PW-1:0]  mag;
    int             fq;
    int             nq;

    always_comb begin
        fq = lane_first_q(mode_i, QIDX);
        nq = lane_nq(mode_i);
        for (int i = 0; i < OPW; i++)
            amask[i] = ((i / QW) >= fq) && ((i / QW) < fq + nq);
        for (int i = 0; i < PW; i++)
            fmask[i] = ((i / SEGW) >= fq) && ((i / SEGW) < fq + nq);
        mag = {{OPW{1'b0}}, a_i & amask} << SHIFT;
        if (two_i)
            mag = mag << 1;
        else if (!one_i)
            mag = '0;
        // Clip to the lane's own result field so sign bits stay inside it.
        pp_o = (neg_i ? (~mag + PW'(1)) : mag) & fmask;
    end
endmodule

// File: rtl/vpm_seg_sum.sv
module vpm_seg_sum #(
    parameter int PW    = 48,
    parameter int NTERM = 16,
    parameter int NSEG  = 4
) (
    input  logic [NTERM-1:0][PW-1:0] terms_i,
    input  logic [NSEG-1:0]          kill_i,
    output logic [PW-1:0]            sum_o
);
    localparam int SEGW = PW / NSEG;
    localparam int CW   = $clog2(NTERM + 2) + 1;

    logic [SEGW+CW-1:0] acc;
    logic [CW-1:0]      carry;

    always_comb begin
        carry = '0;
        sum_o = '0;
        acc   = '0;
        for (int s = 0; s < NSEG; s++) begin
            acc = {{SEGW{1'b0}}, carry};
            for (int t = 0; t < NTERM; t++)
                acc = acc + {{CW{1'b0}}, terms_i[t][s*SEGW +: SEGW]};
            sum_o[s*SEGW +: SEGW] = acc[SEGW-1:0];
            // kill_i[s]: lane edge above segment s, carry must not cross it
            carry = kill_i[s] ? '0 : acc[SEGW+CW-1:SEGW];
        end
    end
endmodule

// File: rtl/vp_booth_mul.sv
module vp_booth_mul #(
    parameter int OPW = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld_i,
    input  logic [1:0]       mode_i,
    input  logic [OPW-1:0]   a_i,
    input  logic [OPW-1:0]   b_i,
    output logic             out_vld_o,
    output logic [2*OPW-1:0] prod_o
);
    import vpm_pkg::*;

    localparam int PW    = 2 * OPW;
    localparam int QW    = OPW / NQ;
    localparam int SEGW  = 2 * QW;
    localparam int HW    = OPW / 2;
    localparam int NDIG  = OPW / 2;
    localparam int NTERM = NDIG + NQ;

    typedef struct packed {
        logic          vld;
        logic [PW-1:0] prod;
    } state_t;

    state_t st_d, st_q;

    logic [NTERM-1:0][PW-1:0] terms;
    logic [NQ-1:0]            kill;
    logic [PW-1:0]            sum_w;

    // Booth digits over the multiplier; recoding restarts at active lane edges.
    for (genvar d = 0; d < NDIG; d++) begin : g_dig
        logic lo, neg, one, two;
        if (d == 0) begin : g_lo0
            assign lo = 1'b0;
        end else if (((2 * d) % QW) == 0) begin : g_loedge
            assign lo = split_at(mode_i, (2 * d) / QW) ? 1'b0 : b_i[2*d-1];
        end else begin : g_lomid
            assign lo = b_i[2*d-1];
        end
        vpm_booth_digit u_enc (
            .grp_i ({b_i[2*d+1], b_i[2*d], lo}),
            .neg_o (neg),
            .one_o (one),
            .two_o (two)
        );
        vpm_pp_row #(.OPW(OPW), .SHIFT(2 * d), .QIDX((2 * d) / QW)) u_row (
            .mode_i (mode_i),
            .a_i    (a_i),
            .neg_i  (neg),
            .one_i  (one),
            .two_i  (two),
            .pp_o   (terms[d])
        );
    end

    // Extra top digit per lane: corrects the unsigned top bit (R9).
    for (genvar j = 0; j < NQ; j++) begin : g_top
        logic top_on;
        assign top_on = b_i[QW*(j+1)-1] & ((j == NQ - 1) || split_at(mode_i, j + 1));
        vpm_pp_row #(.OPW(OPW), .SHIFT(QW * (j + 1)), .QIDX(j)) u_row (
            .mode_i (mode_i),
            .a_i    (a_i),
            .neg_i  (1'b0),
            .one_i  (top_on),
            .two_i  (1'b0),
            .pp_o   (terms[NDIG+j])
        );
        if (j < NQ - 1) begin : g_kill
            assign kill[j] = split_at(mode_i, j + 1);
        end else begin : g_killtop
            assign kill[j] = 1'b1;
        end
    end

    vpm_seg_sum #(.PW(PW), .NTERM(NTERM), .NSEG(NQ)) u_sum (
        .terms_i (terms),
        .kill_i  (kill),
        .sum_o   (sum_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld_i;
        if (in_vld_i)
            st_d.prod = sum_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_vld_o = st_q.vld;
    assign prod_o    = st_q.prod;

    // ---------------- assertions ----------------
    assert_full_product_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld_i && (mode_i == VPM_ONE || mode_i == VPM_ALT)) |=>
        (prod_o == $past({{OPW{1'b0}}, a_i} * {{OPW{1'b0}}, b_i})));

    for (genvar k = 0; k < 2; k++) begin : g_chk2
        assert_half_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (in_vld_i && mode_i == VPM_TWO) |=>
            (prod_o[k*OPW +: OPW] ==
             $past({{HW{1'b0}}, a_i[k*HW +: HW]} * {{HW{1'b0}}, b_i[k*HW +: HW]})));
    end

    for (genvar k = 0; k < NQ; k++) begin : g_chk4
        assert_quarter_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_vld_i && mode_i == VPM_FOUR) |=>
            (prod_o[k*SEGW +: SEGW] ==
             $past({{QW{1'b0}}, a_i[k*QW +: QW]} * {{QW{1'b0}}, b_i[k*QW +: QW]})));
    end

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld_i |=> $stable(prod_o));

endmodule

// File: tb/vp_booth_mul_bench.sv
module vp_booth_mul_bench;

    localparam int W = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b1;
    logic          in_vld = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [W-1:0]  a = '0;
    logic [W-1:0]  b = '0;
    logic          out_vld;
    logic [2*W-1:0] prod;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    logic           exp_vld;
    logic [2*W-1:0] exp_prod;
    string          exp_tag;

    always #5 clk = ~clk;

    vp_booth_mul #(.OPW(W)) u_vp_booth_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vld_i  (in_vld),
        .mode_i    (mode),
        .a_i       (a),
        .b_i       (b),
        .out_vld_o (out_vld),
        .prod_o    (prod)
    );

    function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] x, input logic [W-1:0] y,
                                               input logic [1:0] m);
        int lw;
        logic [2*W-1:0] r;
        longint unsigned msk, xl, yl;
        lw = (m == 2'b10) ? W / 4 : (m == 2'b01) ? W / 2 : W;
        msk = (64'd1 << lw) - 64'd1;
        r = '0;
        for (int k = 0; k < W / lw; k++) begin
            xl = (64'(x) >> (lw * k)) & msk;
            yl = (64'(y) >> (lw * k)) & msk;
            r = r | (2*W)'((xl * yl) << (2 * lw * k));
        end
        return r;
    endfunction

    // Behavioural model, one register stage.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_vld  <= 1'b0;
            exp_prod <= '0;
            exp_tag  <= "R1";
        end else begin
            exp_vld <= in_vld;
            if (in_vld) begin
                exp_prod <= ref_mul(a, b, mode);
                exp_tag  <= cur_tag;
            end else begin
                exp_tag  <= "R10";
            end
        end
    end

    always @(negedge clk) begin
        if (chk_on && !done) begin
            n_chk++;
            if (out_vld !== exp_vld) begin
                n_fail++;
                $display("FAIL R2 out_vld actual=%0b expected=%0b", out_vld, exp_vld);
            end
            n_chk++;
            if (prod !== exp_prod) begin
                n_fail++;
                $display("FAIL %s prod actual=%h expected=%h", exp_tag, prod, exp_prod);
            end
        end
    end

    task automatic op(input logic v, input logic [1:0] m, input logic [W-1:0] x,
                      input logic [W-1:0] y, input string tag);
        @(negedge clk);
        in_vld  = v;
        mode    = m;
        a       = x;
        b       = y;
        cur_tag = tag;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        #2 rst_n = 1'b0;
        chk_on = 1'b1;               // R1 checked during reset
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3: full width
        op(1'b1, 2'b00, 24'h000000, 24'h000000, "R3");
        op(1'b1, 2'b00, 24'h000001, 24'hFFFFFF, "R3");
        op(1'b1, 2'b00, 24'hFFFFFF, 24'hFFFFFF, "R9");
        op(1'b1, 2'b00, 24'hAAAAAA, 24'h555555, "R3");
        for (int i = 0; i < 20; i++) op(1'b1, 2'b00, W'($urandom), W'($urandom), "R3");

        // R4: two lanes
        op(1'b1, 2'b01, 24'hFFFFFF, 24'hFFFFFF, "R9");
        op(1'b1, 2'b01, 24'hAAAAAA, 24'hAAAAAA, "R7");
        op(1'b1, 2'b01, 24'h000FFF, 24'hFFF800, "R7");
        for (int i = 0; i < 20; i++) op(1'b1, 2'b01, W'($urandom), W'($urandom), "R4");

        // R5: four lanes
        op(1'b1, 2'b10, 24'hFFFFFF, 24'hFFFFFF, "R9");
        op(1'b1, 2'b10, 24'hAAAAAA, 24'h2AAAAA, "R7");
        op(1'b1, 2'b10, 24'h00003F, 24'hE38E20, "R7");
        for (int i = 0; i < 20; i++)
            op(1'b1, 2'b10, {W'($urandom)} & 24'hFFFFC0 | 24'h00002B,
               {W'($urandom)} & 24'hFFFFC0 | 24'h000035, "R7");
        for (int i = 0; i < 20; i++) op(1'b1, 2'b10, W'($urandom), W'($urandom), "R5");

        // R6: reserved code acts as full width
        op(1'b1, 2'b11, 24'hFFFFFF, 24'h800001, "R6");
        for (int i = 0; i < 10; i++) op(1'b1, 2'b11, W'($urandom), W'($urandom), "R6");

        // R10: idle cycles with busy inputs keep the last result
        op(1'b1, 2'b00, 24'h123456, 24'h654321, "R3");
        for (int i = 0; i < 6; i++) op(1'b0, 2'($urandom), W'($urandom), W'($urandom), "R10");

        // R8: mode changes every cycle, with gaps
        for (int i = 0; i < 200; i++)
            op(($urandom % 5) != 0, 2'($urandom), W'($urandom), W'($urandom), "R8");
        op(1'b1, 2'b10, 24'hFFFFFF, 24'hFFFFFF, "R8");
        op(1'b1, 2'b00, 24'hFFFFFF, 24'hFFFFFF, "R8");
        op(1'b1, 2'b01, 24'hFFFFFF, 24'hFFFFFF, "R8");

        op(1'b0, 2'b00, '0, '0, "R10");
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule